// File: doc/BRIEF.md
# Register-Mapped Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a simple word-wide register port and drives one interrupt line. Software loads an interval into a period register, which also loads the live counter at once. It then sets command bits in a control word to launch or halt the countdown. The counter steps down by one on each clock cycle in which the count-enable input is high. That input lets an external prescaler slow the count.

When the count runs out, a sticky timeout flag is raised. The timer then either reloads the interval and keeps going, or halts, depending on the auto-reload bit. The interrupt line is high while both the timeout flag and the interrupt-enable bit are set. Software clears the flag by writing the status word with any data. The live count can be read at any time through a read-only snapshot word. An error strobe marks accesses that hit nothing writable.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset, every register reads zero, the counter is stopped, and `irq` and `bus_err` are low.
- R2: Word addresses 0 to 3 select status, control, period and snapshot. Any other address reads as zero and a write to it changes nothing. One cycle after an access to such an address, or after a write to snapshot, `bus_err` is high for one cycle.
- R3: Status bit 0 is the sticky timeout flag and bit 1 is the running flag. A status write clears bit 0 whatever the data, and it never changes bit 1.
- R4: Control bit 0 enables the interrupt, bit 1 selects auto-reload, bit 2 is the launch command and bit 3 is the halt command. A control write stores the whole word, and it reads back unchanged.
- R5: A control write with bit 3 set stops the counter. With only bit 2 set, it starts the counter. With both bits set, the counter is stopped. With neither bit set, the run state is kept.
- R6: A period write stores the value. It also loads the counter, so snapshot shows the value from the next cycle.
- R7: While running, the counter drops by one in each cycle with `tick_en` high. It holds its value when stopped or when `tick_en` is low.
- R8: A counted cycle that starts at a count of 0 or 1 is an expiry, and it sets the timeout flag. Without auto-reload, the counter then reads 0 and stops.
- R9: With auto-reload, an expiry reloads the stored period and the counter stays running. A period of N therefore gives one expiry every N counted cycles.
- R10: `irq` equals the timeout flag ANDed with control bit 0.
- R11: If an expiry falls in the same cycle as a status write, the timeout flag ends up set.
- R12: A write to snapshot leaves the counter and all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable (prescale strobe) |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bus_err | output | 1 | One-cycle strobe for an access to an unmapped address or a write to snapshot |
| irq | output | 1 | Interrupt request |

## Verification
The delicate overlap is an expiry in the same cycle as a status write that clears the flag. A control or period write landing on an expiry cycle is a second such overlap. The bench forces the first case with a directed sequence: it counts a small period down to 1, then issues the status write on the counted cycle. It then lets random traffic with short periods and a busy count enable produce many more overlaps. A bench reference model, built from the requirements, predicts every register and output after each cycle. A register is judged only when its value read through the port differs from the model's prediction.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        IDX_STAT   = 2'd0,
        IDX_CTRL   = 2'd1,
        IDX_PERIOD = 2'd2,
        IDX_SNAP   = 2'd3
    } reg_idx_e;

    localparam int ST_TIMEOUT = 0;
    localparam int ST_RUNNING = 1;
    localparam int CT_IRQ_EN  = 0;
    localparam int CT_AUTO    = 1;
    localparam int CT_GO      = 2;
    localparam int CT_HALT    = 3;

    typedef struct packed {
        logic load;
        logic go;
        logic halt;
    } tmr_cmd_t;

    function automatic logic addr_mapped(input logic [31:0] word_addr);
        return (word_addr >> 2) == 32'd0;
    endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  tmr_pkg::tmr_cmd_t    cmd,
    input  logic [DATA_W-1:0]    load_val,
    input  logic [DATA_W-1:0]    period,
    input  logic                 auto_mode,
    output logic [DATA_W-1:0]    cnt,
    output logic                 run,
    output logic                 expire
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic step;
    assign step   = run && tick && !cmd.load;
    assign expire = step && (cnt <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.load) begin
            cnt <= load_val;
        end else if (step) begin
            if (cnt <= ONE) cnt <= auto_mode ? period : '0;
            else            cnt <= cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        run <= 1'b0;
        else if (cmd.halt)              run <= 1'b0;
        else if (cmd.go)                run <= 1'b1;
        else if (expire && !auto_mode)  run <= 1'b0;
    end

    p_dec_r7: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !cmd.load && cnt > ONE) |=> cnt == $past(cnt) - ONE);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!(run && tick) && !cmd.load) |=> $stable(cnt));
    p_halt_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> !run);
    p_oneshot_r8: assert property (@(posedge clk) disable iff (rst)
        (expire && !auto_mode && !cmd.go) |=> (!run && cnt == '0));
    p_reload_r9: assert property (@(posedge clk) disable iff (rst)
        (expire && auto_mode && !cmd.halt) |=> (run && cnt == $past(period)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 expire,
    input  logic [DATA_W-1:0]    cnt,
    input  logic                 run,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_err,
    output tmr_pkg::tmr_cmd_t    cmd,
    output logic [DATA_W-1:0]    period,
    output logic                 auto_mode,
    output logic                 irq
);
    import tmr_pkg::*;

    logic              mapped, wr;
    reg_idx_e          idx;
    logic [DATA_W-1:0] ctrl_q;
    logic              to_q;
    logic              wr_stat, wr_ctrl, wr_per, wr_snap;

    assign mapped  = addr_mapped(32'(bus_addr));
    assign idx     = reg_idx_e'(bus_addr[1:0]);
    assign wr      = bus_sel && bus_we && mapped;
    assign wr_stat = wr && idx == IDX_STAT;
    assign wr_ctrl = wr && idx == IDX_CTRL;
    assign wr_per  = wr && idx == IDX_PERIOD;
    assign wr_snap = wr && idx == IDX_SNAP;

    assign cmd.load  = wr_per;
    assign cmd.go    = wr_ctrl && bus_wdata[CT_GO];
    assign cmd.halt  = wr_ctrl && bus_wdata[CT_HALT];
    assign auto_mode = ctrl_q[CT_AUTO];
    assign irq       = to_q && ctrl_q[CT_IRQ_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            period  <= '0;
            to_q    <= 1'b0;
            bus_err <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_per)  period <= bus_wdata;
            if (expire)       to_q <= 1'b1;
            else if (wr_stat) to_q <= 1'b0;
            bus_err <= bus_sel && (!mapped || wr_snap);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            unique case (idx)
                IDX_STAT: begin
                    bus_rdata[ST_TIMEOUT] = to_q;
                    bus_rdata[ST_RUNNING] = run;
                end
                IDX_CTRL:   bus_rdata = ctrl_q;
                IDX_PERIOD: bus_rdata = period;
                IDX_SNAP:   bus_rdata = cnt;
                default:    bus_rdata = '0;
            endcase
        end
    end

    p_to_set_r8: assert property (@(posedge clk) disable iff (rst)
        expire |=> to_q);
    p_to_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !expire) |=> !to_q);
    p_collide_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && expire) |=> bus_rdata[ST_TIMEOUT] || !(bus_addr[1:0] == 2'd0 && mapped) || to_q);
    p_err_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !mapped) |=> bus_err);
    p_irq_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(expire || wr_ctrl));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq
);
    tmr_pkg::tmr_cmd_t  cmd;
    logic [DATA_W-1:0]  cnt, period;
    logic               run, expire, auto_mode;

    tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (expire),
        .cnt       (cnt),
        .run       (run),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .cmd       (cmd),
        .period    (period),
        .auto_mode (auto_mode),
        .irq       (irq)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .cmd       (cmd),
        .load_val  (bus_wdata),
        .period    (period),
        .auto_mode (auto_mode),
        .cnt       (cnt),
        .run       (run),
        .expire    (expire)
    );
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        bus_err, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_cnt, m_per, m_ctrl, last_rd;
    logic        m_run, m_to, m_err;

    always #10 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return {30'd0, m_run, m_to};
    endfunction

    task automatic model_step(input logic s, input logic w, input logic [3:0] a,
                              input logic [31:0] d, input logic t);
        logic wr, ld, ex, cont;
        wr   = s && w && (a < 4'd4);
        ld   = wr && a == 4'd2;
        cont = m_ctrl[1];
        ex   = m_run && t && !ld && (m_cnt <= 32'd1);
        m_err = s && ((a >= 4'd4) || (w && a == 4'd3));
        if (ex) m_to = 1'b1;
        else if (wr && a == 4'd0) m_to = 1'b0;
        if (ld) m_cnt = d;
        else if (m_run && t) m_cnt = (m_cnt <= 32'd1) ? (cont ? m_per : 32'd0) : m_cnt - 32'd1;
        if (wr && a == 4'd1 && d[3]) m_run = 1'b0;
        else if (wr && a == 4'd1 && d[2]) m_run = 1'b1;
        else if (ex && !cont) m_run = 1'b0;
        if (ld) m_per = d;
        if (wr && a == 4'd1) m_ctrl = d;
    endtask

    task automatic compare(input string tag);
        bus_addr = 4'd0; #1 check(tag, "status R3", bus_rdata, m_status());
        bus_addr = 4'd1; #1 check(tag, "control R4", bus_rdata, m_ctrl);
        bus_addr = 4'd2; #1 check(tag, "period R6", bus_rdata, m_per);
        bus_addr = 4'd3; #1 check(tag, "snapshot R7", bus_rdata, m_cnt);
        check(tag, "irq R10", 32'(irq), 32'(m_to & m_ctrl[0]));
        check(tag, "bus_err R2", 32'(bus_err), 32'(m_err));
    endtask

    task automatic op(input logic s, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input logic t, input string tag);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; tick_en = t;
        #1 last_rd = bus_rdata;
        model_step(s, w, a, d, t);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
        compare(tag);
    endtask

    initial begin
        m_cnt = 0; m_per = 0; m_ctrl = 0; m_run = 0; m_to = 0; m_err = 0;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");
        check("R1", "irq after reset", 32'(irq), 32'd0);

        op(1, 1, 4'd1, 32'h0000_0003, 0, "R4");
        op(1, 1, 4'd2, 32'd3, 0, "R6");
        check("R6", "snapshot loaded", m_cnt, 32'd3);
        op(1, 1, 4'd1, 32'h0000_000F, 0, "R5");
        check("R5", "both commands stop", m_status(), 32'd0);
        op(1, 1, 4'd1, 32'h0000_0007, 0, "R5");
        op(0, 0, 4'd0, 32'd0, 1, "R7");
        op(0, 0, 4'd0, 32'd0, 0, "R7");
        op(0, 0, 4'd0, 32'd0, 1, "R7");
        op(0, 0, 4'd0, 32'd0, 1, "R9");
        check("R9", "reload count", m_cnt, 32'd3);
        check("R10", "irq raised", 32'(irq), 32'd1);
        op(1, 1, 4'd0, 32'h0, 0, "R3");
        op(0, 0, 4'd0, 32'd0, 1, "R11");
        op(0, 0, 4'd0, 32'd0, 1, "R11");
        op(1, 1, 4'd0, 32'hFFFF_FFFF, 1, "R11");
        check("R11", "timeout kept on collision", 32'(m_to), 32'd1);
        op(1, 1, 4'd3, 32'hDEAD_BEEF, 0, "R12");
        check("R2", "err after snapshot write", 32'(bus_err), 32'd1);
        op(1, 0, 4'd9, 32'd0, 0, "R2");
        check("R2", "unmapped read data", last_rd, 32'd0);
        op(1, 1, 4'd2, 32'd2, 0, "R8");
        op(1, 1, 4'd1, 32'h0000_0004, 0, "R8");
        op(0, 0, 4'd0, 32'd0, 1, "R8");
        op(0, 0, 4'd0, 32'd0, 1, "R8");
        check("R8", "one-shot stopped", m_status(), 32'd1);
        check("R10", "irq masked", 32'(irq), 32'd0);

        for (int i = 0; i < 3000; i++) begin
            int unsigned k;
            logic t;
            k = $urandom % 8;
            t = ($urandom % 4) != 0;
            case (k)
                1: op(1, 1, 4'd0, $urandom, t, "RND");
                2: op(1, 1, 4'd1, {$urandom, 4'b0} | ($urandom % 16), t, "RND");
                3: op(1, 1, 4'd2, $urandom % 6, t, "RND");
                4: op(1, 1, 4'd3, $urandom, t, "RND");
                5: op(1, 1'($urandom), 4'(4 + $urandom % 12), $urandom, t, "RND");
                6: op(1, 0, 4'($urandom % 4), 32'd0, t, "RND");
                default: op(0, 0, 4'd0, 32'd0, t, "RND");
            endcase
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule